// File: doc/BRIEF.md
# Spawn-Join Thread Dispatcher

This block controls a small array of thread processing units that switch between serial mode and parallel mode. In serial mode a spawn command opens a parallel section. The command carries an inclusive range of virtual thread numbers. Every number in that range is then handed to a unit when that unit becomes free. All spawned threads run the same code, so a grant carries only a thread number.

Each unit reports a finished thread with a one-cycle done pulse. Any number of units that finish in the same cycle are all served in one allocation cycle. A prefix count over the request vector gives the lowest-indexed requester the next free number, the next requester that number plus one, and so on. A requester that finds the range used up is parked as finished.

A one-cycle extra-thread request grows the range by one number while the section runs, and it wakes the parked units. Once every unit is parked and no extra request is pending, the block joins and returns to serial mode.

Top module: `thread_dispatch`

## Requirements
- R1: After reset the block is in serial mode: `serial_ready` is 1, `par_active` is 0 and `grant_valid` is all zeros.
- R2: A `spawn_valid` pulse seen in serial mode sets `par_active` and clears `serial_ready` from the following cycle.
- R3: One cycle after parallel mode starts, every unit receives a number. Unit k gets `spawn_lo + k`, as long as that value is not above `spawn_hi`. Each grant is shown as a one-cycle `grant_valid[k]` with its number on `grant_id[k*ID_W +: ID_W]`.
- R4: Units whose `unit_done` bits pulse in the same cycle all receive their next numbers together, with `grant_valid` high two clock edges after the pulse.
- R5: Numbers are issued in ascending order without gaps or repeats. Within one cycle, a lower-indexed unit always holds a smaller number than a higher-indexed one.
- R6: A unit that asks for work after the highest number has been issued receives no grant and stays parked.
- R7: `serial_ready` rises exactly one cycle after the cycle in which all units are parked, provided no extra-thread request is present. Once in serial mode the block stays there until a spawn arrives.
- R8: A spawn whose low number is greater than its high number issues no grants and returns to serial mode three cycles after the spawn pulse.
- R9: An `extra_req` pulse in parallel mode raises the highest number by one and returns every parked unit to requesting. The lowest-indexed of them then receives the new number.
- R10: An `extra_req` pulse in the cycle where all units are parked holds the block in parallel mode for that cycle.
- R11: A `spawn_valid` pulse during parallel mode is ignored and does not change the numbers issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spawn_valid | input | 1 | Spawn command, one cycle |
| spawn_lo | input | ID_W | Lowest thread number of the spawn |
| spawn_hi | input | ID_W | Highest thread number of the spawn |
| extra_req | input | 1 | Add one thread to the running section |
| unit_done | input | N_UNITS | Per-unit pulse: current thread finished |
| grant_valid | output | N_UNITS | Per-unit pulse: new thread number issued |
| grant_id | output | N_UNITS*ID_W | Per-unit issued thread number |
| par_active | output | 1 | Parallel mode |
| serial_ready | output | 1 | Serial mode, join complete |

## Verification
The allocator is driven with several patterns. A full initial burst shows whether the prefix ordering by unit index is right. Two non-adjacent units finishing together tell a combining allocator apart from one that serves a single unit per cycle. A burst that arrives after the range is used up shows that exhausted requests are parked rather than granted. An empty range, an extra request that lands just as every unit parks, and an extra request in the middle of a section separate correct join timing from early or late joins. A spawn sent during a parallel section checks that the running range is left unchanged.

// File: rtl/td_pkg.sv
package td_pkg;
  typedef enum logic [1:0] {
    SLOT_REQ  = 2'd0,
    SLOT_BUSY = 2'd1,
    SLOT_DONE = 2'd2
  } slot_st_t;

  typedef enum logic {
    MODE_SERIAL = 1'b0,
    MODE_PAR    = 1'b1
  } mode_t;
endpackage

// File: rtl/td_prefix.sv
// Exclusive prefix count of a request vector: rank of each requester.
module td_prefix #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic [N-1:0]    req,
  output logic [N*CW-1:0] rank,
  output logic [CW-1:0]   total
);
  always_comb begin
    logic [CW-1:0] acc;
    acc  = '0;
    rank = '0;
    for (int i = 0; i < N; i++) begin
      rank[i*CW +: CW] = acc;
      acc = acc + CW'(req[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/td_slot.sv
// Per-unit tracking state and registered grant.
module td_slot
  import td_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            alloc_ok,
  input  logic            alloc_fail,
  input  logic            extra,
  input  logic            done_in,
  input  logic [ID_W-1:0] cand_id,
  output slot_st_t        st,
  output logic            grant_valid,
  output logic [ID_W-1:0] grant_id
);
  slot_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start) begin
      st_d = SLOT_REQ;
    end else begin
      unique case (st_q)
        SLOT_REQ: begin
          if (alloc_ok)        st_d = SLOT_BUSY;
          else if (alloc_fail) st_d = extra ? SLOT_REQ : SLOT_DONE;
        end
        SLOT_BUSY: if (done_in) st_d = SLOT_REQ;
        SLOT_DONE: if (extra)   st_d = SLOT_REQ;
        default:                st_d = SLOT_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SLOT_DONE;
      grant_valid <= 1'b0;
      grant_id    <= '0;
    end else begin
      st_q        <= st_d;
      grant_valid <= alloc_ok;
      if (alloc_ok) grant_id <= cand_id;
    end
  end

  assign st = st_q;
endmodule

// File: rtl/td_mode.sv
// Serial/parallel mode machine with next and highest thread numbers.
module td_mode
  import td_pkg::*;
#(
  parameter int ID_W = 8,
  parameter int CW   = 3,
  localparam int IW  = ID_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spawn_valid,
  input  logic [ID_W-1:0] spawn_lo,
  input  logic [ID_W-1:0] spawn_hi,
  input  logic            all_done,
  input  logic            extra,
  input  logic [CW-1:0]   n_ok,
  output logic            par,
  output logic            start,
  output logic [IW-1:0]   next_id,
  output logic [IW-1:0]   hi_id
);
  mode_t         mode_q, mode_d;
  logic [IW-1:0] next_q, next_d, hi_q, hi_d;
  logic          ld_en;

  always_comb begin
    mode_d = mode_q;
    next_d = next_q;
    hi_d   = hi_q;
    ld_en  = 1'b0;
    start  = (mode_q == MODE_SERIAL) && spawn_valid;
    if (start) begin
      mode_d = MODE_PAR;
      next_d = {1'b0, spawn_lo};
      hi_d   = {1'b0, spawn_hi};
      ld_en  = 1'b1;
    end else if (mode_q == MODE_PAR) begin
      next_d = next_q + IW'(n_ok);
      hi_d   = hi_q + IW'(extra);
      ld_en  = 1'b1;
      if (all_done && !extra) mode_d = MODE_SERIAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SERIAL;
      next_q <= '0;
      hi_q   <= '0;
    end else begin
      mode_q <= mode_d;
      if (ld_en) begin
        next_q <= next_d;
        hi_q   <= hi_d;
      end
    end
  end

  assign par     = (mode_q == MODE_PAR);
  assign next_id = next_q;
  assign hi_id   = hi_q;
endmodule

// File: rtl/thread_dispatch.sv
module thread_dispatch
  import td_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int ID_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spawn_valid,
  input  logic [ID_W-1:0]         spawn_lo,
  input  logic [ID_W-1:0]         spawn_hi,
  input  logic                    extra_req,
  input  logic [N_UNITS-1:0]      unit_done,
  output logic [N_UNITS-1:0]      grant_valid,
  output logic [N_UNITS*ID_W-1:0] grant_id,
  output logic                    par_active,
  output logic                    serial_ready
);
  localparam int IW = ID_W + 1;
  localparam int CW = $clog2(N_UNITS + 1);

  logic                 par, start, all_done, extra_ok;
  logic [IW-1:0]        next_id, hi_id;
  logic [N_UNITS-1:0]   req_v, ok_v, fail_v, done_v;
  logic [N_UNITS*CW-1:0] rank;
  logic [CW-1:0]        req_total, n_ok;
  logic [N_UNITS*IW-1:0] cand;
  slot_st_t             st [N_UNITS];

  assign extra_ok = extra_req && par;
  assign all_done = &done_v;

  td_prefix #(.N(N_UNITS), .CW(CW)) u_prefix (
    .req   (req_v),
    .rank  (rank),
    .total (req_total)
  );

  for (genvar k = 0; k < N_UNITS; k++) begin : g_slot
    assign req_v[k]  = (st[k] == SLOT_REQ);
    assign done_v[k] = (st[k] == SLOT_DONE);
    assign cand[k*IW +: IW] = next_id + IW'(rank[k*CW +: CW]);
    assign ok_v[k]   = par && req_v[k] && (cand[k*IW +: IW] <= hi_id);
    assign fail_v[k] = par && req_v[k] && (cand[k*IW +: IW] >  hi_id);

    td_slot #(.ID_W(ID_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .alloc_ok    (ok_v[k]),
      .alloc_fail  (fail_v[k]),
      .extra       (extra_ok),
      .done_in     (unit_done[k]),
      .cand_id     (cand[k*IW +: ID_W]),
      .st          (st[k]),
      .grant_valid (grant_valid[k]),
      .grant_id    (grant_id[k*ID_W +: ID_W])
    );
  end

  // Granted count: requesters are ranked, so grants form a prefix of them.
  always_comb begin
    n_ok = '0;
    for (int k = 0; k < N_UNITS; k++) n_ok = n_ok + CW'(ok_v[k]);
  end

  td_mode #(.ID_W(ID_W), .CW(CW)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .spawn_valid (spawn_valid),
    .spawn_lo    (spawn_lo),
    .spawn_hi    (spawn_hi),
    .all_done    (all_done),
    .extra       (extra_ok),
    .n_ok        (n_ok),
    .par         (par),
    .start       (start),
    .next_id     (next_id),
    .hi_id       (hi_id)
  );

  assign par_active   = par;
  assign serial_ready = !par;

  logic unused_total;
  assign unused_total = ^req_total;
endmodule

// File: rtl/td_checker.sv
module td_checker #(
  parameter int N_UNITS = 4,
  parameter int ID_W    = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    spawn_valid,
  input logic                    extra_req,
  input logic [N_UNITS-1:0]      grant_valid,
  input logic [N_UNITS*ID_W-1:0] grant_id,
  input logic                    par_active,
  input logic                    serial_ready
);
  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (serial_ready && grant_valid == '0));

  // R2
  spawn_enters_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spawn_valid && serial_ready) |=> par_active);

  // R3
  grant_only_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid != '0) |-> par_active);

  // R7
  serial_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_ready && !spawn_valid) |=> serial_ready);

  // R10
  extra_blocks_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_active && extra_req) |=> par_active);

  for (genvar i = 0; i < N_UNITS; i++) begin : g_i
    for (genvar j = i + 1; j < N_UNITS; j++) begin : g_j
      // R5
      id_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid[i] && grant_valid[j]) |->
        (grant_id[i*ID_W +: ID_W] < grant_id[j*ID_W +: ID_W]));
    end
  end
endmodule

bind thread_dispatch td_checker #(.N_UNITS(N_UNITS), .ID_W(ID_W)) u_td_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .spawn_valid  (spawn_valid),
  .extra_req    (extra_req),
  .grant_valid  (grant_valid),
  .grant_id     (grant_id),
  .par_active   (par_active),
  .serial_ready (serial_ready)
);

// File: tb/thread_dispatch_bench.sv
module thread_dispatch_bench;
  localparam int N    = 4;
  localparam int ID_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            spawn_valid;
  logic [ID_W-1:0] spawn_lo, spawn_hi;
  logic            extra_req;
  logic [N-1:0]    unit_done;
  logic [N-1:0]    grant_valid;
  logic [N*ID_W-1:0] grant_id;
  logic            par_active, serial_ready;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct { int unit; int id; string req; } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  thread_dispatch #(.N_UNITS(N), .ID_W(ID_W)) u_thread_dispatch (
    .clk(clk), .rst_n(rst_n), .spawn_valid(spawn_valid), .spawn_lo(spawn_lo),
    .spawn_hi(spawn_hi), .extra_req(extra_req), .unit_done(unit_done),
    .grant_valid(grant_valid), .grant_id(grant_id),
    .par_active(par_active), .serial_ready(serial_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int unit, input int id, input string req);
    exp_t e;
    e.unit = unit; e.id = id; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every observed grant must match the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < N; k++) begin
        if (grant_valid[k]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected grant", k, -1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(e.unit == k, e.req, k, e.unit);
            chk(int'(grant_id[k*ID_W +: ID_W]) == e.id, e.req,
                int'(grant_id[k*ID_W +: ID_W]), e.id);
          end
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; spawn_valid = 1'b0; spawn_lo = '0; spawn_hi = '0;
    extra_req = 1'b0; unit_done = '0;
    step(3);
    rst_n = 1'b1;
    step;
    // R1 reset state
    chk(serial_ready == 1'b1, "R1 serial_ready", serial_ready, 1);
    chk(par_active == 1'b0, "R1 par_active", par_active, 0);
    chk(grant_valid == '0, "R1 grant_valid", grant_valid, 0);

    // Sequence A: range 10..15
    spawn_lo = 8'd10; spawn_hi = 8'd15; spawn_valid = 1'b1;
    step; spawn_valid = 1'b0;
    chk(par_active == 1'b1, "R2 par_active", par_active, 1);
    chk(serial_ready == 1'b0, "R2 serial_ready", serial_ready, 0);
    push(0, 10, "R3"); push(1, 11, "R3"); push(2, 12, "R3"); push(3, 13, "R3");
    // R11: spawn during parallel mode must not disturb the range
    spawn_lo = 8'd40; spawn_hi = 8'd50; spawn_valid = 1'b1;
    step; spawn_valid = 1'b0;
    unit_done = 4'b1010;
    step; unit_done = '0;
    push(1, 14, "R4 R11"); push(3, 15, "R4 R11");
    step;
    unit_done = 4'b0101;
    step; unit_done = '0;
    step;
    chk(par_active == 1'b1, "R6 still parallel", par_active, 1);
    unit_done = 4'b1010;
    step; unit_done = '0;
    step;
    chk(serial_ready == 1'b0, "R7 not yet joined", serial_ready, 0);
    step;
    chk(serial_ready == 1'b1, "R7 joined", serial_ready, 1);
    chk(exp_q.size() == 0, "R5 all numbers issued", exp_q.size(), 0);
    step(2);
    chk(serial_ready == 1'b1, "R7 stays serial", serial_ready, 1);

    // Sequence B: range 0..1 with an extra thread
    spawn_lo = 8'd0; spawn_hi = 8'd1; spawn_valid = 1'b1;
    step; spawn_valid = 1'b0;
    push(0, 0, "R3"); push(1, 1, "R3");
    step;
    extra_req = 1'b1;
    step; extra_req = 1'b0;
    push(2, 2, "R9");
    step;
    unit_done = 4'b0111;
    step; unit_done = '0;
    step;
    chk(serial_ready == 1'b0, "R7 B before join", serial_ready, 0);
    step;
    chk(serial_ready == 1'b1, "R7 B joined", serial_ready, 1);

    // Sequence C: empty range
    spawn_lo = 8'd5; spawn_hi = 8'd4; spawn_valid = 1'b1;
    step; spawn_valid = 1'b0;
    chk(par_active == 1'b1, "R8 entered parallel", par_active, 1);
    step;
    chk(serial_ready == 1'b0, "R8 parked", serial_ready, 0);
    step;
    chk(serial_ready == 1'b1, "R8 empty join", serial_ready, 1);

    // Sequence D: extra request as all units park
    spawn_lo = 8'd20; spawn_hi = 8'd19; spawn_valid = 1'b1;
    step; spawn_valid = 1'b0;
    step;
    extra_req = 1'b1;
    step; extra_req = 1'b0;
    chk(par_active == 1'b1, "R10 join held", par_active, 1);
    push(0, 20, "R9 R10");
    step;
    chk(serial_ready == 1'b0, "R10 running", serial_ready, 0);
    unit_done = 4'b0001;
    step; unit_done = '0;
    step(2);
    chk(serial_ready == 1'b1, "R7 D joined", serial_ready, 1);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    step(2);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule